// File: doc/BRIEF.md
# Down-Counting Periodic Interrupt Timer

This block is a down counter that raises a sticky flag each time it counts through zero, and drives one interrupt line from that flag. Software programs it through a small word-indexed register port. Each port has its own write strobe and its own read index. A write takes effect on the clock edge. A read returns the registered state of the selected word combinationally.

The count rate comes from one of two tick-enable inputs, a fast main tick or a slow tick. The selected tick passes through a divider whose ratio is held in the control word. When the counter steps past zero, it either reloads from the load register or wraps to all ones. A control bit picks between these two modes. A load write can optionally overwrite the running count at once. A status write of any value acknowledges the flag. A soft-reset bit in the control word returns the block to its power-on state.

Top module: `dntmr_top`

## Requirements
- R1: Word indices: 0 control, 1 status (flag at bit 0), 2 load, 3 compare, 4 counter (read-only; writes ignored). Indices 5 to 7 read as zero. Control keeps only bits 25:0, and bit 16 always reads as 0.
- R2: Control bits 25:24 pick the source tick: 00 none, 01 or 10 `tick_main`, 11 `tick_slow`. The counter takes one step per (P+1) ticks of that source, where P is control bits 15:4. The divider restarts on every control write, and no step happens in that cycle.
- R3: A step with a nonzero counter decrements it by one.
- R4: A step with the counter at zero sets the flag. The counter then loads the load register if control bit 3 is 1, or all ones if it is 0.
- R5: Any write to index 1 clears the flag, whatever the data. A zero step in the same cycle wins, and the flag stays set.
- R6: `irq` is high exactly when the flag is set and control bit 2 is 1.
- R7: A load write stores the value. With control bit 17 set, the counter takes the same value on the same edge, and any step in that cycle is dropped. With bit 17 clear, the counter is untouched.
- R8: A control write that leaves bit 0 set, a nonzero source and bit 1 clear copies the load register into the counter. With bit 1 set, the counter keeps its value. With bit 0 clear or source 00, the counter holds.
- R9: A control write with bit 16 set clears the flag and compare, sets load and counter to all ones, and then applies the other written control bits. The R8 copy then uses the new all-ones load value.
- R10: After hardware reset: control 0, flag 0, compare 0, load all ones, counter all ones, `irq` low.
- R11: Compare is plain read/write storage and never affects the counter, the flag or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_main | input | 1 | Fast count-source enable pulse |
| tick_slow | input | 1 | Slow count-source enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Word index of the write |
| wdata | input | DW | Write data |
| rd_idx | input | 3 | Word index of the read |
| rdata | output | DW | Read data of the selected word |
| irq | output | 1 | Interrupt, flag gated by the enable bit |

## Verification
The bench goes after several same-cycle collisions. The first is an acknowledge landing on the very edge where the counter passes zero; a design that lets the clear win would lose an interrupt. The second is a load overwrite in a cycle where the divider also fires; a design that applies both would end one count short. The bench also covers soft reset combined with enable in one write, where the counter must start from all ones and not from the stale load value. It also checks the wrap mode, where a design that reloads instead would give a short second period, and divider ratios above zero on both tick sources, where an off-by-one divider shows up as drift against the reference count.

// File: rtl/dntmr_pkg.sv
package dntmr_pkg;

    localparam int IDX_W   = 3;
    localparam int PRE_W   = 12;
    localparam int CTRL_W  = 26;
    localparam int SWR_BIT = 16;

    typedef enum logic [IDX_W-1:0] {
        RI_CTRL = 3'd0,
        RI_STAT = 3'd1,
        RI_LOAD = 3'd2,
        RI_CMP  = 3'd3,
        RI_CNT  = 3'd4
    } reg_idx_e;

    // Field layout of the control word, MSB first (bit 25 down to bit 0).
    typedef struct packed {
        logic [1:0]       src;    // 25:24 tick source
        logic [5:0]       spare;  // 23:18 stored only
        logic             ovw;    // 17 load write overwrites counter
        logic             swr;    // 16 soft reset, never stored as 1
        logic [PRE_W-1:0] presc;  // 15:4 divider ratio minus one
        logic             rld;    // 3 reload (1) or wrap to ones (0)
        logic             ien;    // 2 interrupt enable
        logic             emod;   // 1 keep counter on enable
        logic             en;     // 0 run
    } ctrl_t;

endpackage

// File: rtl/dntmr_presc.sv
module dntmr_presc #(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          tick,
    input  logic [PW-1:0] limit,
    output logic          step
);
    logic [PW-1:0] pcnt_d, pcnt_q;

    always_comb begin
        step   = run && tick && !clr && (pcnt_q == limit);
        pcnt_d = pcnt_q;
        if (clr)
            pcnt_d = '0;
        else if (run && tick)
            pcnt_d = step ? '0 : pcnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    // R2: with a ratio above one, two steps never fall on adjacent cycles
    a_r2_step_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (step && limit != '0) |=> !step);

endmodule

// File: rtl/dntmr_core.sv
module dntmr_core #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          rld,
    input  logic          force_en,
    input  logic [DW-1:0] force_val,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] cnt_q,
    output logic          wrap
);
    logic [DW-1:0] cnt_d;
    logic          at_zero;

    always_comb begin
        at_zero = (cnt_q == '0);
        wrap    = step && !force_en && at_zero;
        cnt_d   = cnt_q;
        if (force_en)
            cnt_d = force_val;
        else if (step)
            cnt_d = at_zero ? (rld ? load_val : '1) : cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '1;
        else        cnt_q <= cnt_d;
    end

    // R3: an unforced step from nonzero lowers the count by one
    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !force_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R4: wrap mode lands on all ones
    a_r4_wrap_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !rld) |=> (cnt_q == '1));

    // R8: no step and no force leaves the count alone
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !force_en) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/dntmr_top.sv
module dntmr_top
    import dntmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_main,
    input  logic             tick_slow,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rdata,
    output logic             irq
);
    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] load;
        logic [DW-1:0] cmp;
        logic          flag;
    } regs_t;

    regs_t         r_d, r_q;
    ctrl_t         new_ctrl;
    logic          wr_ctrl, wr_stat, wr_load, wr_cmp, swr;
    logic          run, src_tick, step, wrap;
    logic          cnt_force;
    logic [DW-1:0] cnt_fval, cnt_q;

    // ---------------- write decode and next state ----------------
    always_comb begin
        wr_ctrl      = wr_en && (wr_idx == RI_CTRL);
        wr_stat      = wr_en && (wr_idx == RI_STAT);
        wr_load      = wr_en && (wr_idx == RI_LOAD);
        wr_cmp       = wr_en && (wr_idx == RI_CMP);
        swr          = wr_ctrl && wdata[SWR_BIT];
        new_ctrl     = ctrl_t'(wdata[CTRL_W-1:0]);
        new_ctrl.swr = 1'b0;

        run = r_q.ctrl.en && (r_q.ctrl.src != 2'b00);
        case (r_q.ctrl.src)
            2'b00:   src_tick = 1'b0;
            2'b11:   src_tick = tick_slow;
            default: src_tick = tick_main;
        endcase

        cnt_force = 1'b0;
        cnt_fval  = wdata;
        if (wr_ctrl && new_ctrl.en && new_ctrl.src != 2'b00 && !new_ctrl.emod) begin
            cnt_force = 1'b1;
            cnt_fval  = swr ? '1 : r_q.load;
        end else if (swr) begin
            cnt_force = 1'b1;
            cnt_fval  = '1;
        end else if (wr_load && r_q.ctrl.ovw) begin
            cnt_force = 1'b1;
            cnt_fval  = wdata;
        end

        r_d = r_q;
        if (swr) begin
            r_d.load = '1;
            r_d.cmp  = '0;
        end
        if (wr_ctrl) r_d.ctrl = new_ctrl;
        if (wr_load) r_d.load = wdata;
        if (wr_cmp)  r_d.cmp  = wdata;
        if (wrap)
            r_d.flag = 1'b1;
        else if (wr_stat || swr)
            r_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl <= '0;
            r_q.load <= '1;
            r_q.cmp  <= '0;
            r_q.flag <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    // ---------------- datapath ----------------
    dntmr_presc #(.PW(PRE_W)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_ctrl),
        .run   (run),
        .tick  (src_tick),
        .limit (r_q.ctrl.presc),
        .step  (step)
    );

    dntmr_core #(.DW(DW)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .rld       (r_q.ctrl.rld),
        .force_en  (cnt_force),
        .force_val (cnt_fval),
        .load_val  (r_q.load),
        .cnt_q     (cnt_q),
        .wrap      (wrap)
    );

    // ---------------- read side ----------------
    always_comb begin
        case (rd_idx)
            RI_CTRL: rdata = {{(DW-CTRL_W){1'b0}}, r_q.ctrl};
            RI_STAT: rdata = {{(DW-1){1'b0}}, r_q.flag};
            RI_LOAD: rdata = r_q.load;
            RI_CMP:  rdata = r_q.cmp;
            RI_CNT:  rdata = cnt_q;
            default: rdata = '0;
        endcase
        irq = r_q.flag && r_q.ctrl.ien;
    end

    // R4: a zero step always leaves the flag set
    a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> r_q.flag);

    // R5: acknowledge without a competing zero step clears the flag
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !wrap) |=> !r_q.flag);

    // R6: interrupt stays low while masked
    a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.ctrl.ien |-> !irq);

    // R7: overwrite write puts the data into the counter on the next edge
    a_r7_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load && r_q.ctrl.ovw) |=> (cnt_q == $past(wdata)));

    // R9: soft reset restores load, compare and flag, bit 16 self-clears
    a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> (r_q.load == '1 && r_q.cmp == '0 && !r_q.flag && !r_q.ctrl.swr));

endmodule

// File: tb/test_dntmr_top.sv
module test_dntmr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_main = 1'b0, tick_slow = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0, rd_idx = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    int    main_pat = 0;
    bit    done = 1'b0;
    string phase = "R10";

    dntmr_top #(.DW(32)) i_dntmr_top (
        .clk(clk), .rst_n(rst_n), .tick_main(tick_main), .tick_slow(tick_slow),
        .wr_en(wr_en), .wr_idx(wr_idx), .wdata(wdata),
        .rd_idx(rd_idx), .rdata(rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    // ---------------- behavioural reference ----------------
    logic [31:0] m_ctrl, m_load, m_cmp, m_cnt;
    bit          m_flag;
    int          m_pc;

    always @(posedge clk) begin
        bit          run, tk, stepped, zero_evt;
        logic [31:0] nxt;
        if (!rst_n) begin
            m_ctrl = 0; m_load = 32'hFFFF_FFFF; m_cmp = 0;
            m_cnt = 32'hFFFF_FFFF; m_flag = 0; m_pc = 0;
        end else begin
            run      = m_ctrl[0] && (m_ctrl[25:24] != 2'b00);
            tk       = (m_ctrl[25:24] == 2'b11) ? tick_slow : tick_main;
            stepped  = 0;
            zero_evt = 0;
            if (wr_en && wr_idx == 0) m_pc = 0;
            else if (run && tk) begin
                if (m_pc == int'(m_ctrl[15:4])) begin m_pc = 0; stepped = 1; end
                else m_pc = m_pc + 1;
            end
            nxt = m_cnt;
            if (stepped && !(wr_en && wr_idx == 2 && m_ctrl[17])) begin
                if (m_cnt == 0) begin
                    zero_evt = 1;
                    nxt = m_ctrl[3] ? m_load : 32'hFFFF_FFFF;
                end else nxt = m_cnt - 1;
            end
            if (wr_en) begin
                case (wr_idx)
                    3'd0: begin
                        if (wdata[16]) begin
                            m_load = 32'hFFFF_FFFF; m_cmp = 0; m_flag = 0;
                            nxt = 32'hFFFF_FFFF;
                        end
                        m_ctrl = wdata & 32'h03FE_FFFF;
                        if (m_ctrl[0] && m_ctrl[25:24] != 0 && !m_ctrl[1]) nxt = m_load;
                    end
                    3'd1: m_flag = 0;
                    3'd2: begin if (m_ctrl[17]) nxt = wdata; m_load = wdata; end
                    3'd3: m_cmp = wdata;
                    default: ;
                endcase
            end
            if (zero_evt) m_flag = 1;
            m_cnt = nxt;
        end
    end

    function automatic logic [31:0] exp_read(input logic [2:0] idx);
        case (idx)
            3'd0: return m_ctrl;
            3'd1: return {31'd0, m_flag};
            3'd2: return m_load;
            3'd3: return m_cmp;
            3'd4: return m_cnt;
            default: return 32'd0;
        endcase
    endfunction

    // compare away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (rdata !== exp_read(rd_idx)) begin
                n_fail++;
                $display("FAIL %s read idx %0d: actual %h expected %h", phase, rd_idx, rdata, exp_read(rd_idx));
            end
            n_chk++;
            if (irq !== (m_flag && m_ctrl[2])) begin
                n_fail++;
                $display("FAIL %s (R6 irq): actual %b expected %b", phase, irq, m_flag && m_ctrl[2]);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input bit we, input logic [2:0] idx, input logic [31:0] d);
        @(posedge clk); #1;
        cyc++;
        wr_en  = we; wr_idx = idx; wdata = d;
        rd_idx = rd_idx + 3'd1;
        tick_main = (main_pat == 0) ? 1'b1 : (cyc % 3 == 0);
        tick_slow = (cyc % 5 == 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 3'd0, 32'd0);
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        drive(1, idx, d);
        drive(0, 3'd0, 32'd0);
    endtask

    localparam logic [31:0] EN = 32'h1, EMOD = 32'h2, IEN = 32'h4, RLD = 32'h8,
                            SWR = 32'h1_0000, OVW = 32'h2_0000,
                            S_MAIN = 32'h0100_0000, S_ALT = 32'h0200_0000, S_SLOW = 32'h0300_0000;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        phase = "R10"; idle(8);
        phase = "R1";  wr(3'd0, 32'hFC00_0000); wr(3'd4, 32'h55); idle(8);
        phase = "R11"; wr(3'd3, 32'h1234_5678); idle(4);
        phase = "R2";  wr(3'd2, 32'd5); wr(3'd0, EN | RLD | S_MAIN | (32'd2 << 4)); idle(40);
        main_pat = 1;  idle(40);
        wr(3'd0, EN | RLD | S_SLOW); idle(40);
        main_pat = 0;  wr(3'd0, EN | RLD | S_ALT | (32'd1 << 4)); idle(20);
        phase = "R3";  wr(3'd2, 32'd9); wr(3'd0, EN | RLD | S_MAIN); idle(24);
        phase = "R4";  wr(3'd2, 32'd3); wr(3'd0, EN | S_MAIN); idle(12);
        phase = "R6";  wr(3'd0, EN | EMOD | IEN | S_MAIN); idle(6);
                       wr(3'd0, EN | EMOD | S_MAIN); idle(4);
                       wr(3'd0, EN | EMOD | IEN | S_MAIN); idle(4);
        phase = "R5";  wr(3'd1, 32'd0); idle(3); wr(3'd1, 32'hFFFF_FFFF);
                       wr(3'd2, 32'd2); wr(3'd0, EN | RLD | IEN | S_MAIN);
                       for (int i = 0; i < 14; i++) drive(1, 3'd1, 32'(i));
                       idle(4);
        phase = "R7";  wr(3'd0, EN | EMOD | RLD | OVW | S_MAIN); drive(1, 3'd2, 32'h40); idle(6);
                       wr(3'd0, EN | EMOD | RLD | OVW | S_MAIN | (32'd3 << 4)); idle(3);
                       for (int i = 0; i < 4; i++) drive(1, 3'd2, 32'h20 + 32'(i));
                       idle(5);
                       wr(3'd0, EN | EMOD | RLD | S_MAIN); drive(1, 3'd2, 32'h7); idle(10);
        phase = "R8";  wr(3'd2, 32'h30); wr(3'd0, EN | EMOD | RLD | S_MAIN); idle(6);
                       wr(3'd0, EMOD | RLD | S_MAIN); idle(8);
                       wr(3'd0, EN | RLD); idle(8);
                       wr(3'd0, EN | RLD | S_MAIN); idle(8);
        phase = "R9";  wr(3'd3, 32'hABCD); wr(3'd0, SWR | EN | IEN | S_MAIN); idle(10);
                       wr(3'd0, SWR); idle(8);
        phase = "R11"; wr(3'd2, 32'd4); wr(3'd3, 32'd0); wr(3'd0, EN | RLD | IEN | S_MAIN);
                       wr(3'd3, 32'd2); idle(12);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule